// File: doc/BRIEF.md
# Shared Cell Buffer Admission Controller

This block decides whether a cell offered on the transmit side may enter a common store of cell slots that sixteen per-link queues share. Every link has a software-programmed ceiling on how many cells it may hold. The total of the link ceilings may be larger than the store itself, so a cell is taken only when two things are true: the link is below its ceiling and the store still has a free slot. The block counts occupancy per link and free slots in the store. It raises a per-link cell-available line when that link could take one more cell.

The slot memory and the scheduler that drains the queues sit outside this block. The scheduler appears here only as a dequeue pulse that carries a link index. A sticky flag records that a cell was turned away because the store was exhausted. Software clears that flag by writing a zero to it. A dequeue aimed at an empty link leaves all state unchanged and produces a one-cycle error pulse.

Top module: `cell_quota_buf`

## Requirements
- R1: After reset, the store has 118 free slots and every link occupancy is 0. Every link ceiling is 7, all sixteen `clav_o` bits are 1, and `sts_nofree_o` and `deq_err_o` are 0.
- R2: `enq_accept_o` is combinational and is 1 in the same cycle exactly when all three hold: `enq_valid_i` is 1, the store has at least one free slot, and the addressed link's occupancy is below its ceiling. An accepted cell raises that link's occupancy by one and lowers the free count by one at the next clock edge.
- R3: A configuration write sets the addressed link's ceiling from the next cycle on. A ceiling of 0 blocks the link. A ceiling lowered below the present occupancy blocks new cells until the occupancy drops below it.
- R4: After each clock edge, `clav_o[i]` is 1 exactly when link i's occupancy is below its ceiling and the store has at least one free slot.
- R5: While the store has no free slot, every offered cell is refused whatever the link quotas allow, and `clav_o` is all zeros.
- R6: A cell offered while the store has no free slot sets `sts_nofree_o` at the next edge. The flag then stays at 1 until it is cleared.
- R7: A status write with `sts_wdata_i` = 0 clears the flag at the next edge. A status write with 1 has no effect. When a set and a clear fall in the same cycle, the set wins.
- R8: A dequeue on a link whose occupancy is above 0 lowers that occupancy and raises the free count, each by one, at the next edge. A dequeue on an empty link changes nothing and drives `deq_err_o` to 1 for the one following cycle.
- R9: An enqueue and a dequeue in the same cycle are each judged on the state before that edge and are both applied. When they address the same link, that link's occupancy and the free count end unchanged. A dequeue that frees a slot does not admit a cell offered to a full store in the same cycle.
- R10: A cell refused only because its link is at its ceiling, while the store still has free slots, leaves `sts_nofree_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Ceiling write strobe |
| cfg_link_i | input | 4 | Link addressed by the ceiling write |
| cfg_len_i | input | 7 | New ceiling, in cells |
| enq_valid_i | input | 1 | A cell is offered |
| enq_link_i | input | 4 | Link of the offered cell |
| enq_accept_o | output | 1 | Offered cell is admitted this cycle |
| deq_valid_i | input | 1 | A cell leaves a queue |
| deq_link_i | input | 4 | Link the cell leaves |
| deq_err_o | output | 1 | Previous dequeue addressed an empty link |
| clav_o | output | 16 | Per-link cell-available |
| sts_wr_i | input | 1 | Status flag write strobe |
| sts_wdata_i | input | 1 | Status write data (0 clears) |
| sts_nofree_o | output | 1 | Sticky store-exhausted flag |

## Verification
The admit decision is combinational, so the bench checks `enq_accept_o` one nanosecond after it drives the offer, in the same cycle. Every registered result is due one cycle after its stimulus: the per-link `clav_o`, the sticky flag and the dequeue error pulse each pass through exactly one register. The driver task therefore pushes the expected post-edge values into a queue. The monitor pops and compares them one nanosecond after the very next rising edge, so each expectation is matched to its own edge.

// File: rtl/cqb_pkg.sv
`timescale 1ns/1ps
package cqb_pkg;
  localparam int unsigned NUM_LINKS_DEF  = 16;
  localparam int unsigned POOL_CELLS_DEF = 118;
  localparam int unsigned DEF_LEN_DEF    = 7;

  typedef enum logic [1:0] {
    STS_HOLD = 2'd0,
    STS_SET  = 2'd1,
    STS_CLR  = 2'd2
  } sts_op_e;
endpackage

// File: rtl/cqb_pool_ctr.sv
`timescale 1ns/1ps
module cqb_pool_ctr #(
  parameter int unsigned POOL_CELLS = 118,
  parameter int unsigned CNT_W      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             give_i,
  output logic [CNT_W-1:0] free_o,
  output logic             room_o
);
  logic [CNT_W-1:0] free_q, free_d;

  always_comb begin
    free_d = free_q;
    unique case ({take_i, give_i})
      2'b10:   free_d = free_q - CNT_W'(1);
      2'b01:   free_d = free_q + CNT_W'(1);
      default: free_d = free_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= CNT_W'(POOL_CELLS);
    else         free_q <= free_d;
  end

  assign free_o = free_q;
  assign room_o = (free_q != '0);
endmodule

// File: rtl/cqb_link_occ.sv
`timescale 1ns/1ps
module cqb_link_occ #(
  parameter int unsigned CNT_W   = 7,
  parameter int unsigned DEF_LEN = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             len_we_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             inc_i,
  input  logic             dec_req_i,
  output logic [CNT_W-1:0] occ_o,
  output logic             room_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] occ_q, occ_d, len_q;
  logic             dec_ok;

  assign empty_o = (occ_q == '0);
  assign dec_ok  = dec_req_i & ~empty_o;

  always_comb begin
    occ_d = occ_q;
    unique case ({inc_i, dec_ok})
      2'b10:   occ_d = occ_q + CNT_W'(1);
      2'b01:   occ_d = occ_q - CNT_W'(1);
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      len_q <= CNT_W'(DEF_LEN);
    end else begin
      occ_q <= occ_d;
      if (len_we_i) len_q <= len_i;
    end
  end

  assign occ_o  = occ_q;
  assign room_o = (occ_q < len_q);
endmodule

// File: rtl/cqb_sts_flag.sv
`timescale 1ns/1ps
module cqb_sts_flag
  import cqb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_refuse_i,
  input  logic sts_wr_i,
  input  logic sts_wdata_i,
  input  logic deq_empty_i,
  output logic sts_o,
  output logic deq_err_o
);
  sts_op_e op;
  logic    sts_q, err_q;

  // set dominates a same-cycle clear
  always_comb begin
    if (full_refuse_i)                op = STS_SET;
    else if (sts_wr_i && !sts_wdata_i) op = STS_CLR;
    else                              op = STS_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= deq_empty_i;
      unique case (op)
        STS_SET: sts_q <= 1'b1;
        STS_CLR: sts_q <= 1'b0;
        default: sts_q <= sts_q;
      endcase
    end
  end

  assign sts_o     = sts_q;
  assign deq_err_o = err_q;
endmodule

// File: rtl/cell_quota_buf.sv
`timescale 1ns/1ps
module cell_quota_buf
  import cqb_pkg::*;
#(
  parameter int unsigned NUM_LINKS  = NUM_LINKS_DEF,
  parameter int unsigned POOL_CELLS = POOL_CELLS_DEF,
  parameter int unsigned DEF_LEN    = DEF_LEN_DEF,
  localparam int unsigned LINK_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int unsigned CNT_W     = $clog2(POOL_CELLS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [LINK_W-1:0]    cfg_link_i,
  input  logic [CNT_W-1:0]     cfg_len_i,
  input  logic                 enq_valid_i,
  input  logic [LINK_W-1:0]    enq_link_i,
  output logic                 enq_accept_o,
  input  logic                 deq_valid_i,
  input  logic [LINK_W-1:0]    deq_link_i,
  output logic                 deq_err_o,
  output logic [NUM_LINKS-1:0] clav_o,
  input  logic                 sts_wr_i,
  input  logic                 sts_wdata_i,
  output logic                 sts_nofree_o
);
  logic [NUM_LINKS-1:0]            link_room, link_empty;
  logic [NUM_LINKS-1:0][CNT_W-1:0] link_occ;
  logic [CNT_W-1:0]                pool_free;
  logic                            pool_room;
  logic                            enq_in_range, deq_in_range;
  logic                            deq_hit, deq_empty;

  assign enq_in_range = (32'(enq_link_i) < NUM_LINKS);
  assign deq_in_range = (32'(deq_link_i) < NUM_LINKS);

  assign enq_accept_o = enq_valid_i & enq_in_range & pool_room & link_room[enq_link_i];
  assign deq_hit      = deq_valid_i & deq_in_range & ~link_empty[deq_link_i];
  assign deq_empty    = deq_valid_i & deq_in_range & link_empty[deq_link_i];

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    cqb_link_occ #(
      .CNT_W  (CNT_W),
      .DEF_LEN(DEF_LEN)
    ) u_occ (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .len_we_i (cfg_we_i && (32'(cfg_link_i) == g)),
      .len_i    (cfg_len_i),
      .inc_i    (enq_accept_o && (32'(enq_link_i) == g)),
      .dec_req_i(deq_valid_i && (32'(deq_link_i) == g)),
      .occ_o    (link_occ[g]),
      .room_o   (link_room[g]),
      .empty_o  (link_empty[g])
    );
    assign clav_o[g] = link_room[g] & pool_room;
  end

  cqb_pool_ctr #(
    .POOL_CELLS(POOL_CELLS),
    .CNT_W     (CNT_W)
  ) u_pool (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(enq_accept_o),
    .give_i(deq_hit),
    .free_o(pool_free),
    .room_o(pool_room)
  );

  cqb_sts_flag u_sts (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .full_refuse_i(enq_valid_i & ~pool_room),
    .sts_wr_i     (sts_wr_i),
    .sts_wdata_i  (sts_wdata_i),
    .deq_empty_i  (deq_empty),
    .sts_o        (sts_nofree_o),
    .deq_err_o    (deq_err_o)
  );
endmodule

// File: rtl/cell_quota_buf_chk.sv
`timescale 1ns/1ps
module cell_quota_buf_chk #(
  parameter int unsigned NUM_LINKS  = 16,
  parameter int unsigned POOL_CELLS = 118,
  parameter int unsigned CNT_W      = 7,
  parameter int unsigned LINK_W     = 4
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            enq_valid_i,
  input logic [LINK_W-1:0]               enq_link_i,
  input logic                            enq_accept_o,
  input logic                            deq_valid_i,
  input logic                            deq_err_o,
  input logic [NUM_LINKS-1:0]            clav_o,
  input logic                            sts_wr_i,
  input logic                            sts_wdata_i,
  input logic                            sts_nofree_o,
  input logic [NUM_LINKS-1:0][CNT_W-1:0] link_occ,
  input logic [CNT_W-1:0]                pool_free
);
  logic [15:0] occ_sum;
  always_comb begin
    occ_sum = '0;
    for (int k = 0; k < NUM_LINKS; k++) occ_sum = occ_sum + 16'(link_occ[k]);
  end

  AST_POOL_CONSERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_sum + 16'(pool_free)) == 16'(POOL_CELLS)); // R8

  AST_ACCEPT_HAS_CLAV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_accept_o |-> clav_o[enq_link_i]); // R2

  AST_FULL_REFUSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pool_free == '0) |-> (!enq_accept_o && clav_o == '0)); // R5

  AST_FULL_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_valid_i && pool_free == '0) |=> sts_nofree_o); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_nofree_o && !(sts_wr_i && !sts_wdata_i)) |=> sts_nofree_o); // R7

  AST_DEQ_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deq_err_o) |-> $past(deq_valid_i)); // R8
endmodule

bind cell_quota_buf cell_quota_buf_chk #(
  .NUM_LINKS (NUM_LINKS),
  .POOL_CELLS(POOL_CELLS),
  .CNT_W     (CNT_W),
  .LINK_W    (LINK_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enq_valid_i (enq_valid_i),
  .enq_link_i  (enq_link_i),
  .enq_accept_o(enq_accept_o),
  .deq_valid_i (deq_valid_i),
  .deq_err_o   (deq_err_o),
  .clav_o      (clav_o),
  .sts_wr_i    (sts_wr_i),
  .sts_wdata_i (sts_wdata_i),
  .sts_nofree_o(sts_nofree_o),
  .link_occ    (link_occ),
  .pool_free   (pool_free)
);

// File: tb/cell_quota_buf_tb.sv
`timescale 1ns/1ps
module cell_quota_buf_tb;
  localparam int NL = 16;
  localparam int POOL = 118;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, enq_v = 0, deq_v = 0, sts_wr = 0, sts_wd = 0;
  logic [3:0] cfg_l = 0, enq_l = 0, deq_l = 0;
  logic [6:0] cfg_len = 0;
  logic enq_acc, deq_err, sts;
  logic [NL-1:0] clav;

  int n_checks = 0, n_fail = 0;
  int m_len[NL], m_occ[NL];
  int m_free;
  bit m_sts;

  logic [NL-1:0] q_clav[$];
  bit q_sts[$], q_err[$];
  string q_tag[$];

  always #2 clk = ~clk;

  cell_quota_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_link_i(cfg_l), .cfg_len_i(cfg_len),
    .enq_valid_i(enq_v), .enq_link_i(enq_l), .enq_accept_o(enq_acc),
    .deq_valid_i(deq_v), .deq_link_i(deq_l), .deq_err_o(deq_err),
    .clav_o(clav), .sts_wr_i(sts_wr), .sts_wdata_i(sts_wd), .sts_nofree_o(sts)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] exp_clav();
    logic [NL-1:0] v;
    for (int i = 0; i < NL; i++) v[i] = (m_occ[i] < m_len[i]) && (m_free > 0);
    return v;
  endfunction

  task automatic step(input bit ev, input int el, input bit dv, input int dl,
                      input bit cw, input int cl, input int clen,
                      input bit sw, input bit sd, input string tag);
    bit acc, dok, derr, set;
    @(negedge clk);
    enq_v = ev; enq_l = 4'(el); deq_v = dv; deq_l = 4'(dl);
    cfg_we = cw; cfg_l = 4'(cl); cfg_len = 7'(clen); sts_wr = sw; sts_wd = sd;
    #1;
    acc = ev && (m_free > 0) && (m_occ[el] < m_len[el]);
    chk(enq_acc === acc, tag, "enq_accept", 32'(enq_acc), 32'(acc));
    dok  = dv && (m_occ[dl] > 0);
    derr = dv && (m_occ[dl] == 0);
    set  = ev && (m_free == 0);
    if (acc) begin m_occ[el]++; m_free--; end
    if (dok) begin m_occ[dl]--; m_free++; end
    if (cw) m_len[cl] = clen;
    if (set) m_sts = 1;
    else if (sw && !sd) m_sts = 0;
    q_clav.push_back(exp_clav());
    q_sts.push_back(m_sts);
    q_err.push_back(derr);
    q_tag.push_back(tag);
  endtask

  task automatic enq(input int l, input string t);  step(1, l, 0, 0, 0, 0, 0, 0, 0, t); endtask
  task automatic deq(input int l, input string t);  step(0, 0, 1, l, 0, 0, 0, 0, 0, t); endtask
  task automatic cfg(input int l, input int n, input string t); step(0, 0, 0, 0, 1, l, n, 0, 0, t); endtask
  task automatic idle(input string t);              step(0, 0, 0, 0, 0, 0, 0, 0, 0, t); endtask
  task automatic stsw(input bit d, input string t); step(0, 0, 0, 0, 0, 0, 0, 1, d, t); endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  endtask

  // monitor: one expectation per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_tag.size() > 0) begin
        logic [NL-1:0] ec;
        bit es, ee;
        string t;
        ec = q_clav.pop_front(); es = q_sts.pop_front();
        ee = q_err.pop_front(); t = q_tag.pop_front();
        chk(clav === ec, t, "clav", 32'(clav), 32'(ec));
        chk(sts === es, t, "sts_nofree", 32'(sts), 32'(es));
        chk(deq_err === ee, t, "deq_err", 32'(deq_err), 32'(ee));
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_len[i] = 7; m_occ[i] = 0; end
    m_free = POOL; m_sts = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(clav === '1, "R1", "clav", 32'(clav), 32'hFFFF);
    chk(sts === 1'b0, "R1", "sts_nofree", 32'(sts), 0);
    chk(deq_err === 1'b0, "R1", "deq_err", 32'(deq_err), 0);
    chk(enq_acc === 1'b0, "R1", "enq_accept", 32'(enq_acc), 0);

    deq(5, "R8 empty");
    idle("R8 pulse end");
    // fill link 0 to its default ceiling, one extra refused by quota
    for (int i = 0; i < 8; i++) enq(0, "R2");
    idle("R10");
    cfg(1, 0, "R3 zero");
    enq(1, "R3 zero");
    cfg(0, 3, "R3 lower");
    enq(0, "R3 lower");
    for (int i = 0; i < 4; i++) deq(0, "R8");
    enq(0, "R3 still");
    deq(0, "R8");
    enq(0, "R3 reopen");
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, "R9 at ceiling");
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, "R9 same link");
    for (int i = 0; i < NL; i++) cfg(i, 10, "R3");
    for (int i = 0; i < 400 && m_free > 0; i++) enq(i % NL, "R4");
    enq(15, "R5");
    enq(2, "R5 R6");
    idle("R6 sticky");
    stsw(1, "R7 write one");
    stsw(0, "R7 clear");
    step(1, 4, 0, 0, 0, 0, 0, 1, 0, "R7 set wins");
    stsw(0, "R7 clear");
    step(1, 3, 1, 3, 0, 0, 0, 0, 0, "R9 full");
    enq(3, "R4 reopened");
    repeat (3) @(negedge clk);
    chk(q_tag.size() == 0, "R4", "pending", 32'(q_tag.size()), 0);
    summary();
  end
endmodule